// File: doc/BRIEF.md
# Synchronous Flow-Through Byte-Write SRAM

This block is a single-port synchronous memory with a 36-bit word. The word is split into four lanes of nine bits each, and every lane holds one data byte and one parity bit. Address, write data, chip enables and write controls are all captured on the rising clock edge. A write completes on its own during the next cycle. A read returns the addressed word in the cycle right after the capturing edge, because the path from the array to the output has no output register.

Three controls decide which lanes a write reaches: a write-all strobe, a lane-write enable and four per-lane selects. The memory takes part in an access only when all three chip enables show their active levels. An output enable acts combinationally on the output drive. A sleep input blocks all new accesses and releases the output, and the stored contents are kept. The depth is a parameter. A separate sequencer supplies any burst addressing.

The output is shown as a data bus `dq_out` plus a drive flag `dq_drive`. When `dq_drive` is 0 the pins are high impedance and `dq_out` reads as zero. The block is a memory and has no flow control, so it applies no back-pressure and can accept one access on every clock.

Top module: `fsbw_sram`

## Requirements
- R1: While reset is asserted and after it is released, with no access captured yet, `dq_drive` is 0.
- R2: A selected write with `wr_all`=1 stores all 36 bits of `wdata` at `addr`. This holds whatever the values of `lane_wr_en` and `lane_sel`.
- R3: A selected write with `wr_all`=0 and `lane_wr_en`=1 updates lane i only where `lane_sel[i]`=1. Lane i is bits [9i+8:9i]. The other lanes keep their old contents.
- R4: When `wr_all`=0 and `lane_wr_en`=0, the cycle is a read and no lane is written, whatever the value of `lane_sel`.
- R5: An access is taken only when `chip_en0_n`=0, `chip_en1`=1 and `chip_en2_n`=0. Any other combination writes nothing, and in the following cycle `dq_drive` is 0.
- R6: After an edge that captures a selected read, `dq_out` shows the addressed word and `dq_drive` equals `out_en` in the same cycle.
- R7: `out_en`=0 forces `dq_drive` to 0 without waiting for a clock edge. Raising it again during a read cycle drives the output again in that same cycle.
- R8: In the cycle after an edge that captures a selected write, `dq_drive` is 0 even when `out_en`=1.
- R9: While `sleep`=1, reads and writes presented at a clock edge are ignored, the stored contents are kept and `dq_drive` is 0.
- R10: The parity bit of each lane (bit 9i+8) is stored and read back like its byte bits.
- R11: A read of an address captured on the edge right after a write to that address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | 36 | Write word, four 9-bit lanes |
| chip_en0_n | input | 1 | Chip enable, active low |
| chip_en1 | input | 1 | Chip enable, active high |
| chip_en2_n | input | 1 | Chip enable, active low |
| wr_all | input | 1 | Write all four lanes |
| lane_wr_en | input | 1 | Enables writing of the lanes selected by lane_sel |
| lane_sel | input | 4 | Per-lane write select |
| out_en | input | 1 | Combinational output enable |
| sleep | input | 1 | Low-power hold; blocks accesses and releases the output |
| dq_out | output | 36 | Read word, zero when not driven |
| dq_drive | output | 1 | 1 while the output is driven, 0 for high impedance |

## Verification
The closest overlap is in one cycle where the write of the previous edge is finishing in the array while a read of the same address is being captured. That read must already see the new word. The bench forces this with back-to-back write and read pairs, both directed and random, and compares the output with a bench model that is updated at each write's capture. A second overlap happens when an output-enable change arrives in the middle of a read cycle. The bench toggles `out_en` between edges and requires `dq_drive` to follow before the next edge.

// File: rtl/fsbw_pkg.sv
package fsbw_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int LANE_W = BYTE_W + 1;
  localparam int WORD_W = LANES * LANE_W;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fsbw_capture.sv
module fsbw_capture
  import fsbw_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  word_t         wdata,
  input  logic          chip_en0_n,
  input  logic          chip_en1,
  input  logic          chip_en2_n,
  input  logic          wr_all,
  input  logic          lane_wr_en,
  input  lane_mask_t    lane_sel,
  input  logic          sleep,
  output logic [AW-1:0] addr_q,
  output word_t         wdata_q,
  output lane_mask_t    wmask_q,
  output logic          rd_q
);
  logic       take;
  lane_mask_t mask_d;

  always_comb begin
    take = !chip_en0_n && chip_en1 && !chip_en2_n && !sleep;
    if (wr_all)          mask_d = '1;
    else if (lane_wr_en) mask_d = lane_sel;
    else                 mask_d = '0;
    if (!take)           mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmask_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      wmask_q <= mask_d;
      rd_q    <= take && (mask_d == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/fsbw_lane_mem.sv
module fsbw_lane_mem
  import fsbw_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= din;
  end

  assign dout = cells[addr];
endmodule

// File: rtl/fsbw_out_gate.sv
module fsbw_out_gate
  import fsbw_pkg::*;
(
  input  logic  rd_q,
  input  logic  out_en,
  input  logic  sleep,
  input  word_t word_in,
  output word_t dq_out,
  output logic  dq_drive
);
  always_comb begin
    dq_drive = rd_q && out_en && !sleep;
    dq_out   = dq_drive ? word_in : '0;
  end
endmodule

// File: rtl/fsbw_sram.sv
module fsbw_sram
  import fsbw_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [35:0]   wdata,
  input  logic          chip_en0_n,
  input  logic          chip_en1,
  input  logic          chip_en2_n,
  input  logic          wr_all,
  input  logic          lane_wr_en,
  input  logic [3:0]    lane_sel,
  input  logic          out_en,
  input  logic          sleep,
  output logic [35:0]   dq_out,
  output logic          dq_drive
);
  logic [AW-1:0] addr_q;
  word_t         wdata_q;
  lane_mask_t    wmask_q;
  logic          rd_q;
  word_t         rd_word;

  fsbw_capture #(.AW(AW)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wdata      (wdata),
    .chip_en0_n (chip_en0_n),
    .chip_en1   (chip_en1),
    .chip_en2_n (chip_en2_n),
    .wr_all     (wr_all),
    .lane_wr_en (lane_wr_en),
    .lane_sel   (lane_sel),
    .sleep      (sleep),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .wmask_q    (wmask_q),
    .rd_q       (rd_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fsbw_lane_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk  (clk),
      .we   (wmask_q[g]),
      .addr (addr_q),
      .din  (wdata_q[g*LANE_W +: LANE_W]),
      .dout (rd_word[g*LANE_W +: LANE_W])
    );
  end

  fsbw_out_gate u_gate (
    .rd_q     (rd_q),
    .out_en   (out_en),
    .sleep    (sleep),
    .word_in  (rd_word),
    .dq_out   (dq_out),
    .dq_drive (dq_drive)
  );
endmodule

// File: rtl/fsbw_sram_chk.sv
module fsbw_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chip_en0_n,
  input logic       chip_en1,
  input logic       chip_en2_n,
  input logic       wr_all,
  input logic       lane_wr_en,
  input logic [3:0] lane_sel,
  input logic       out_en,
  input logic       sleep,
  input logic       dq_drive
);
  logic sel_now, wr_now;
  assign sel_now = !chip_en0_n && chip_en1 && !chip_en2_n && !sleep;
  assign wr_now  = wr_all || (lane_wr_en && (lane_sel != 4'b0));

  // R8: no drive in the cycle after a captured write
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && wr_now) |=> !dq_drive);

  // R5: deselected edge leaves the output undriven
  a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> !dq_drive);

  // R6: a captured read drives exactly when enabled
  a_r6_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && !wr_now) |=> (dq_drive == (out_en && !sleep)));

  // R7: output enable low means no drive
  a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !dq_drive);

  // R9: sleep releases the output
  a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_drive);
endmodule

bind fsbw_sram fsbw_sram_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_en0_n (chip_en0_n),
  .chip_en1   (chip_en1),
  .chip_en2_n (chip_en2_n),
  .wr_all     (wr_all),
  .lane_wr_en (lane_wr_en),
  .lane_sel   (lane_sel),
  .out_en     (out_en),
  .sleep      (sleep),
  .dq_drive   (dq_drive)
);

// File: tb/fsbw_sram_bench.sv
module fsbw_sram_bench;
  localparam int DEPTH = 512;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wdata = '0;
  logic          chip_en0_n = 1'b1, chip_en1 = 1'b0, chip_en2_n = 1'b1;
  logic          wr_all = 1'b0, lane_wr_en = 1'b0;
  logic [3:0]    lane_sel = '0;
  logic          out_en = 1'b0, sleep = 1'b0;
  logic [35:0]   dq_out;
  logic          dq_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [35:0] model [16];

  always #10ns clk = ~clk;

  fsbw_sram #(.DEPTH(DEPTH)) u_fsbw_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .chip_en0_n(chip_en0_n), .chip_en1(chip_en1), .chip_en2_n(chip_en2_n),
    .wr_all(wr_all), .lane_wr_en(lane_wr_en), .lane_sel(lane_sel),
    .out_en(out_en), .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input bit w_all, input bit lwe, input logic [3:0] ls);
    if (w_all) return 4'hF;
    if (lwe)   return ls;
    return 4'h0;
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw, input logic [3:0] m);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  // one access: drive at negedge, capture at posedge, check at next negedge
  task automatic op(input logic [3:0] a, input logic [35:0] d, input bit e0n, input bit e1,
                    input bit e2n, input bit w_all, input bit lwe, input logic [3:0] ls,
                    input bit oe, input bit slp, input string req);
    logic [3:0] m;
    bit act;
    logic [35:0] exp_word;
    @(negedge clk);
    addr = {{(AW-4){1'b0}}, a}; wdata = d;
    chip_en0_n = e0n; chip_en1 = e1; chip_en2_n = e2n;
    wr_all = w_all; lane_wr_en = lwe; lane_sel = ls; out_en = oe; sleep = slp;
    act = !e0n && e1 && !e2n && !slp;
    m = exp_mask(w_all, lwe, ls);
    exp_word = model[a];
    if (act && m != 0) model[a] = merge(model[a], d, m);
    @(negedge clk);
    if (act && m == 0) begin
      chk(dq_drive == oe, req, {35'b0, dq_drive}, {35'b0, oe});
      if (oe) chk(dq_out == exp_word, req, dq_out, exp_word);
    end else begin
      chk(dq_drive == 1'b0, req, {35'b0, dq_drive}, 36'h0);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    op(a, 36'h0, 0, 1, 0, 0, 0, 4'h0, 1, 0, req);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 36'h0, 36'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dq_drive == 1'b0, "R1 in reset", {35'b0, dq_drive}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_drive == 1'b0, "R1 after reset", {35'b0, dq_drive}, 36'h0);

    // R2: fill with write-all; lane controls set to noise
    for (int i = 0; i < 16; i++)
      op(i[3:0], {4{1'b1, i[3:0], 4'h5}} ^ 36'h0_0F0F_0F0F, 0, 1, 0, 1, 0, 4'h2, 1, 0, "R2/R8 write-all");
    for (int i = 0; i < 16; i++) rd(i[3:0], "R2 readback");

    // R3 / R10: lane 2 only, parity bit set
    op(4'd3, 36'hF_FFFF_FFFF, 0, 1, 0, 0, 1, 4'b0100, 1, 0, "R3 lane write");
    rd(4'd3, "R3/R10 lane readback");
    op(4'd4, 36'h8_0402_0100, 0, 1, 0, 0, 1, 4'b1001, 1, 0, "R10 parity lanes");
    rd(4'd4, "R10 parity readback");

    // R4: selects without lane enable
    op(4'd5, 36'h0, 0, 1, 0, 0, 0, 4'hF, 1, 0, "R4 selects only");
    rd(4'd5, "R4 unchanged");

    // R5: each enable wrong
    op(4'd6, 36'h1_2345_6789, 1, 1, 0, 1, 0, 4'h0, 1, 0, "R5 en0 off");
    op(4'd6, 36'h1_2345_6789, 0, 0, 0, 1, 0, 4'h0, 1, 0, "R5 en1 off");
    op(4'd6, 36'h1_2345_6789, 0, 1, 1, 1, 0, 4'h0, 1, 0, "R5 en2 off");
    op(4'd6, 36'h0, 1, 0, 1, 0, 0, 4'h0, 1, 0, "R5 deselected read");
    rd(4'd6, "R5 unchanged");

    // R9: sleep blocks write and read
    op(4'd7, 36'hA_AAAA_AAAA, 0, 1, 0, 1, 0, 4'h0, 1, 1, "R9 sleep write");
    op(4'd7, 36'h0, 0, 1, 0, 0, 0, 4'h0, 1, 1, "R9 sleep read");
    rd(4'd7, "R9 contents kept");

    // R11: write then read immediately, R6 flow-through
    op(4'd8, 36'h5_5AA5_A55A, 0, 1, 0, 1, 0, 4'h0, 1, 0, "R11 write");
    rd(4'd8, "R11/R6 next-cycle read");

    // R7: asynchronous output enable inside a read cycle
    rd(4'd9, "R6 read");
    out_en = 1'b0;
    #1ns;
    chk(dq_drive == 1'b0, "R7 oe low", {35'b0, dq_drive}, 36'h0);
    out_en = 1'b1;
    #1ns;
    chk(dq_drive == 1'b1 && dq_out == model[9], "R7 oe high", dq_out, model[9]);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a = 4'($urandom_range(0, 15));
      bit is_wr = ($urandom_range(0, 1) == 1);
      bit desel = ($urandom_range(0, 7) == 0);
      bit slp = ($urandom_range(0, 9) == 0);
      logic [35:0] d = {4'($urandom), $urandom};
      op(a, d, desel ? 1'($urandom) : 1'b0, desel ? 1'($urandom) : 1'b1,
         desel ? 1'b1 : 1'b0, is_wr && ($urandom_range(0, 2) == 0), is_wr,
         4'($urandom), 1'($urandom_range(0, 3) != 0), slp, "R2-R11 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule